// File: doc/BRIEF.md
# Serial EEPROM Page-Aware Write Sequencer

This block sits on the host side of a mode-0 SPI serial EEPROM. It drives the chip select, clock and data-out pins and samples data-in. A caller hands it one high-level request at a time over a valid/ready command port. The request can set or clear the device's write latch, read or write the status register, or read or write one or many memory bytes. Bytes to be written are pulled from a valid/ready stream. Bytes read back, including a status byte, leave on a valid strobe. A one-cycle done pulse marks the end of every request.

Memory writes are the part that needs care. Before every write frame, the sequencer sends a write-enable frame of its own. A long write is cut wherever the next address crosses a page boundary. After each cut, and after a status write, it polls the device's busy bit. Polling has a fixed retry limit, and a timeout sets an error flag. Sequential reads stay in one frame for their whole length.

Top module: `spi_eeprom_seq`

## Requirements
- R1: The first byte of each frame is the opcode for its kind: 0x06 latch enable, 0x04 latch disable, 0x05 status read, 0x01 status write, 0x03 memory read, 0x02 memory write. Command codes on `cmd_op` are 0 enable, 1 disable, 2 status read, 3 status write, 4 memory read, 5 memory write.
- R2: A memory frame sends its opcode, then the high address byte, then the low address byte. Every byte is shifted most significant bit first.
- R3: The clock idles low. Each clock level lasts `SCK_HALF` system cycles. Data-out changes only while the clock is low, and data-in is sampled as the clock rises.
- R4: The clock is low on every cycle in which chip select changes level.
- R5: A memory-write or status-write frame always follows a frame holding only opcode 0x06.
- R6: A memory write is closed after any byte whose successor address is a multiple of `PAGE_BYTES` (32). If bytes remain, the write-enable frame and a new write frame resume at the next address.
- R7: After each memory-write or status-write frame, status-read frames repeat until bit 0 of the returned byte is 0, up to `MAX_POLLS` (100) frames. If the limit is reached, `err` sets and holds until the next command is accepted.
- R8: A status write sends opcode 0x01 followed by one byte taken from the write stream.
- R9: Data-out is low whenever chip select is high.
- R10: A memory read of length N uses one frame and returns N bytes in address order. A length of 0 is treated as 1.
- R11: `cmd_ready` is high only while idle, and chip select is then high. Each command ends with a `done` pulse that lasts exactly one cycle. Codes 6 and 7 end at once with no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_addr | input | 16 | Start memory address |
| cmd_len | input | LEN_W | Byte count for memory read or write |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte (memory or status) |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Poll timeout flag |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench connects to a behavioural EEPROM model that decodes frames on the pins, keeps a frame log, and can be made to hold its busy bit for a chosen number of polls. The first write is a single byte, which checks the basic enable-write-poll order and the poll count. A 70-byte write that starts five bytes into a page must split into 27-, 32- and 11-byte frames. This catches errors in the page boundary arithmetic and in the enable reissue. A busy bit that never clears separates a correct 100-poll timeout from an endless or early loop. A status write and reads of length 70 and 0 check the single-frame and length-clamp paths.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    localparam logic [2:0] CMD_WREN  = 3'd0;
    localparam logic [2:0] CMD_WRDI  = 3'd1;
    localparam logic [2:0] CMD_RDSR  = 3'd2;
    localparam logic [2:0] CMD_WRSR  = 3'd3;
    localparam logic [2:0] CMD_READ  = 3'd4;
    localparam logic [2:0] CMD_WRITE = 3'd5;

    typedef enum logic [2:0] {
        FR_WREN, FR_WRDI, FR_RDSR, FR_WRSR, FR_READ, FR_WRITE, FR_POLL
    } frame_e;

    typedef enum logic [1:0] {SEG_OP, SEG_AHI, SEG_ALO, SEG_DAT} seg_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPEN, ST_SHIFT, ST_WAITWR, ST_CLOSE
    } state_e;

    function automatic logic [7:0] opcode_of(frame_e f);
        case (f)
            FR_WREN:  return OPC_WREN;
            FR_WRDI:  return OPC_WRDI;
            FR_WRSR:  return OPC_WRSR;
            FR_READ:  return OPC_READ;
            FR_WRITE: return OPC_WRITE;
            default:  return OPC_RDSR;
        endcase
    endfunction

endpackage

// File: rtl/eeseq_shifter.sv
module eeseq_shifter #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sck;
        logic          mosi;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic [2:0]    bidx;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                n.busy = 1'b1;
                n.sh   = tx_byte;
                n.mosi = tx_byte[7];
                n.bidx = '0;
                n.cnt  = '0;
                n.sck  = 1'b0;
            end
        end else if (q.cnt != CW'(HALF - 1)) begin
            n.cnt = q.cnt + 1'b1;
        end else begin
            n.cnt = '0;
            if (!q.sck) begin
                n.sck = 1'b1;
                n.rx  = {q.rx[6:0], miso};
            end else begin
                n.sck = 1'b0;
                if (q.bidx == 3'd7) begin
                    n.busy = 1'b0;
                    n.done = 1'b1;
                    n.mosi = 1'b0;
                end else begin
                    n.bidx = q.bidx + 3'd1;
                    n.sh   = {q.sh[6:0], 1'b0};
                    n.mosi = q.sh[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done    = q.done;
    assign rx_byte = q.rx;
    assign sck     = q.sck;
    assign mosi    = q.mosi;

    // R3: data-out holds while the clock stays high
    p_mosi_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sck && $past(q.sck)) |-> $stable(q.mosi));
    // R9: data-out rests low between bytes
    p_mosi_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.mosi);

endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
    import eeseq_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int MAX_POLLS  = 100,
    parameter int GAP        = 4,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             cmd_ready,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_tx
);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PLW = $clog2(MAX_POLLS + 1);
    localparam int GW  = (GAP > 1) ? $clog2(GAP) : 1;

    typedef struct packed {
        state_e           st;
        frame_e           fr;
        seg_e             seg;
        logic [2:0]       cmd;
        logic [15:0]      addr;
        logic [LEN_W-1:0] rem;
        logic [PLW-1:0]   polls;
        logic [GW-1:0]    gap;
        logic             wip;
        logic             cs_n;
        logic             rd_valid;
        logic [7:0]       rd_data;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t q, n;
    logic [15:0] next_addr;

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        n.rd_valid = 1'b0;
        sh_start   = 1'b0;
        sh_tx      = 8'h00;
        wr_ready   = 1'b0;
        cmd_ready  = (q.st == ST_IDLE);
        next_addr  = q.addr + 16'd1;

        case (q.st)
            ST_IDLE: if (cmd_valid) begin
                n.cmd   = cmd_op;
                n.addr  = cmd_addr;
                n.rem   = (cmd_len == '0) ? LEN_W'(1) : cmd_len;
                n.err   = 1'b0;
                n.polls = '0;
                n.st    = ST_OPEN;
                case (cmd_op)
                    CMD_WREN, CMD_WRSR, CMD_WRITE: n.fr = FR_WREN;
                    CMD_WRDI: n.fr = FR_WRDI;
                    CMD_RDSR: n.fr = FR_RDSR;
                    CMD_READ: n.fr = FR_READ;
                    default: begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end
                endcase
            end

            ST_OPEN: begin
                n.cs_n   = 1'b0;
                sh_start = 1'b1;
                sh_tx    = opcode_of(q.fr);
                n.seg    = SEG_OP;
                n.st     = ST_SHIFT;
            end

            ST_SHIFT: if (sh_done) begin
                case (q.seg)
                    SEG_OP: begin
                        case (q.fr)
                            FR_WREN, FR_WRDI: begin
                                n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                            end
                            FR_RDSR, FR_POLL: begin
                                sh_start = 1'b1; n.seg = SEG_DAT;
                            end
                            FR_WRSR: begin
                                n.st = ST_WAITWR; n.seg = SEG_DAT;
                            end
                            default: begin
                                sh_start = 1'b1; sh_tx = q.addr[15:8]; n.seg = SEG_AHI;
                            end
                        endcase
                    end
                    SEG_AHI: begin
                        sh_start = 1'b1; sh_tx = q.addr[7:0]; n.seg = SEG_ALO;
                    end
                    SEG_ALO: begin
                        n.seg = SEG_DAT;
                        if (q.fr == FR_READ) sh_start = 1'b1;
                        else                 n.st = ST_WAITWR;
                    end
                    default: begin
                        case (q.fr)
                            FR_RDSR: begin
                                n.rd_valid = 1'b1; n.rd_data = sh_rx;
                                n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                            end
                            FR_POLL: begin
                                n.wip = sh_rx[0];
                                n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                            end
                            FR_READ: begin
                                n.rd_valid = 1'b1; n.rd_data = sh_rx;
                                n.rem = q.rem - 1'b1;
                                if (q.rem == LEN_W'(1)) begin
                                    n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                                end else begin
                                    sh_start = 1'b1;
                                end
                            end
                            FR_WRITE: begin
                                n.rem  = q.rem - 1'b1;
                                n.addr = next_addr;
                                if (q.rem == LEN_W'(1) || next_addr[PW-1:0] == '0) begin
                                    n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                                end else begin
                                    n.st = ST_WAITWR;
                                end
                            end
                            default: begin
                                n.st = ST_CLOSE; n.gap = '0; n.cs_n = 1'b1;
                            end
                        endcase
                    end
                endcase
            end

            ST_WAITWR: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    sh_start = 1'b1;
                    sh_tx    = wr_data;
                    n.st     = ST_SHIFT;
                end
            end

            default: begin
                if (q.gap != GW'(GAP - 1)) begin
                    n.gap = q.gap + 1'b1;
                end else begin
                    n.st = ST_OPEN;
                    case (q.fr)
                        FR_WREN: begin
                            if (q.cmd == CMD_WRSR)       n.fr = FR_WRSR;
                            else if (q.cmd == CMD_WRITE) n.fr = FR_WRITE;
                            else begin n.st = ST_IDLE; n.done = 1'b1; end
                        end
                        FR_WRSR, FR_WRITE: begin
                            n.polls = '0;
                            n.fr    = FR_POLL;
                        end
                        FR_POLL: begin
                            if (q.wip && q.polls != PLW'(MAX_POLLS - 1)) begin
                                n.polls = q.polls + 1'b1;
                            end else begin
                                if (q.wip) n.err = 1'b1;
                                if (q.cmd == CMD_WRITE && q.rem != '0) begin
                                    n.fr = FR_WREN;
                                end else begin
                                    n.st = ST_IDLE; n.done = 1'b1;
                                end
                            end
                        end
                        default: begin
                            n.st = ST_IDLE; n.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign done     = q.done;
    assign err      = q.err;
    assign cs_n     = q.cs_n;

    // R11: idle state keeps the device deselected
    p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> q.cs_n);
    // R11: done never lasts two cycles
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R8: stream bytes are only taken inside a selected frame
    p_stream_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !q.cs_n);
    // R7: the poll counter stays below its limit
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls < PLW'(MAX_POLLS));
    // R7: the error flag only rises at the end of a poll frame
    p_err_from_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> ($past(q.fr) == FR_POLL));

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
    parameter int SCK_HALF   = 4,
    parameter int PAGE_BYTES = 32,
    parameter int MAX_POLLS  = 100,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic       sh_start, sh_done;
    logic [7:0] sh_tx, sh_rx;

    eeseq_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_POLLS  (MAX_POLLS),
        .GAP        (SCK_HALF),
        .LEN_W      (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .cmd_ready (cmd_ready),
        .wr_ready  (wr_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .done      (done),
        .err       (err),
        .cs_n      (spi_cs_n),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx)
    );

    eeseq_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi)
    );

    // R4: chip select only moves while the clock is low
    p_cs_edge_sck_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n != $past(spi_cs_n)) |-> !spi_sck);

endmodule

// File: tb/spi_eeprom_seq_test.sv
module spi_eeprom_seq_test;
    localparam int HALF = 2;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic cmd_valid = 0, cmd_ready, wr_valid, wr_ready, rd_valid, done, err;
    logic [2:0] cmd_op = 0;
    logic [15:0] cmd_addr = 0, cmd_len = 0;
    logic [7:0] wr_data, rd_data;
    logic spi_cs_n, spi_sck, spi_mosi, spi_miso = 0;

    spi_eeprom_seq #(.SCK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int n_tests = 0, n_fail = 0, cyc = 0;

    // write stream source and read collector
    logic [7:0] wbuf [0:127];
    logic [7:0] rbuf [0:127];
    int w_idx = 0, w_n = 0, r_n = 0;
    assign wr_valid = (w_idx < w_n);
    assign wr_data  = wbuf[w_idx[6:0]];
    always @(posedge clk) begin
        if (wr_valid && wr_ready) w_idx <= w_idx + 1;
        if (rd_valid) begin rbuf[r_n[6:0]] <= rd_data; r_n <= r_n + 1; end
    end

    // behavioural serial EEPROM with frame log
    logic [7:0] mem [0:1023];
    logic [7:0] m_in = 0, m_op = 0, m_out = 0, m_sr = 0;
    logic [15:0] m_addr = 0;
    logic m_wel = 0, m_wrote = 0;
    int m_bits = 0, m_idx = 0, m_busy = 0, m_busy_len = 0, fc = 0;
    logic [7:0] fr_op [0:511];
    int fr_len [0:511];
    logic fr_wel [0:511];

    function automatic logic [7:0] m_status();
        return {m_sr[7:2], m_wel, (m_busy != 0)};
    endfunction

    always @(negedge spi_cs_n) begin m_bits = 0; m_idx = 0; m_wrote = 0; end
    always @(posedge spi_cs_n) if (m_idx > 0) begin
        fr_op[fc] = m_op; fr_len[fc] = m_idx; fc = fc + 1;
        if (m_wrote) begin m_busy = m_busy_len; m_wel = 0; end
        m_idx = 0;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        m_in = {m_in[6:0], spi_mosi};
        m_bits = m_bits + 1;
        if (m_bits == 8) begin
            m_bits = 0;
            if (m_idx == 0) begin
                m_op = m_in; fr_wel[fc] = m_wel;
                if (m_in == 8'h06) m_wel = 1;
                if (m_in == 8'h04) m_wel = 0;
                if (m_in == 8'h05) begin m_out = m_status(); if (m_busy > 0) m_busy = m_busy - 1; end
            end else if (m_op == 8'h05) m_out = m_status();
            else if (m_op == 8'h01) begin
                if (m_idx == 1 && m_wel) begin m_sr = m_in; m_wrote = 1; end
            end else if (m_op == 8'h02 || m_op == 8'h03) begin
                if (m_idx == 1) m_addr[15:8] = m_in;
                else if (m_idx == 2) m_addr[7:0] = m_in;
                if (m_op == 8'h03 && m_idx >= 2) begin
                    m_out = mem[m_addr[9:0]]; m_addr = m_addr + 1;
                end
                if (m_op == 8'h02 && m_idx >= 3 && m_wel) begin
                    mem[m_addr[9:0]] = m_in; m_wrote = 1;
                    m_addr = {m_addr[15:5], m_addr[4:0] + 5'd1};
                end
            end
            m_idx = m_idx + 1;
        end
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        spi_miso = m_out[7]; m_out = {m_out[6:0], 1'b0};
    end

    // pin-level monitors
    int v_mosi = 0, v_cs = 0, v_half = 0, v_idle = 0, hi_cnt = 0;
    logic p_sck = 0, p_mosi = 0, p_cs = 1;
    always @(negedge clk) if (rst_n) begin
        if (p_sck && spi_sck && spi_mosi != p_mosi) v_mosi++;
        if (spi_cs_n != p_cs && (spi_sck || p_sck)) v_cs++;
        if (spi_cs_n && spi_mosi) v_idle++;
        if (spi_sck) hi_cnt++;
        else begin if (p_sck && hi_cnt != HALF) v_half++; hi_cnt = 0; end
        p_sck = spi_sck; p_mosi = spi_mosi; p_cs = spi_cs_n;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int fc0;
    task automatic do_cmd(input logic [2:0] op, input logic [15:0] a, input logic [15:0] len, input int nwr);
        @(negedge clk);
        r_n = 0; w_idx = 0; w_n = nwr; fc0 = fc;
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_len = len;
        @(posedge clk);
        while (!cmd_ready) @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done, "R11", "done width", done, 0);
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1, "R11", "ready at reset", cmd_ready, 1);
        chk(spi_cs_n == 1 && spi_sck == 0, "R3", "idle pins", {spi_cs_n, spi_sck}, 2);
        chk(done == 0 && err == 0, "R11", "done/err at reset", {done, err}, 0);
    endtask

    task automatic t_latch();
        do_cmd(3'd0, 0, 0, 0);
        chk(fc - fc0 == 1 && fr_op[fc0] == 8'h06 && fr_len[fc0] == 1, "R1", "enable frame", fr_op[fc0], 6);
        do_cmd(3'd2, 0, 0, 0);
        chk(r_n == 1 && rbuf[0] == 8'h02, "R1", "status after enable", rbuf[0], 2);
        do_cmd(3'd1, 0, 0, 0);
        chk(fr_op[fc0] == 8'h04, "R1", "disable opcode", fr_op[fc0], 4);
        do_cmd(3'd2, 0, 0, 0);
        chk(rbuf[0] == 8'h00, "R1", "status after disable", rbuf[0], 0);
        do_cmd(3'd6, 0, 0, 0);
        chk(fc == fc0, "R11", "unused code frames", fc - fc0, 0);
    endtask

    task automatic t_byte();
        m_busy_len = 3; wbuf[0] = 8'hAA;
        do_cmd(3'd5, 16'd155, 1, 1);
        chk(fc - fc0 == 6, "R7", "frames in byte write", fc - fc0, 6);
        chk(fr_op[fc0] == 8'h06 && fr_op[fc0+1] == 8'h02 && fr_wel[fc0+1], "R5", "enable before write", fr_op[fc0], 6);
        chk(fr_len[fc0+1] == 4 && fr_op[fc0+5] == 8'h05, "R7", "write len then polls", fr_len[fc0+1], 4);
        chk(mem[155] == 8'hAA && err == 0, "R2", "byte at address", mem[155], 8'hAA);
        do_cmd(3'd4, 16'd155, 1, 0);
        chk(r_n == 1 && rbuf[0] == 8'hAA && fr_len[fc0] == 4, "R10", "single read", rbuf[0], 8'hAA);
    endtask

    task automatic t_pages();
        int bad;
        m_busy_len = 1;
        for (int i = 0; i < 70; i++) wbuf[i] = 8'(i * 7 + 3);
        do_cmd(3'd5, 16'h01C5, 70, 70);
        chk(fc - fc0 == 12, "R6", "frames for 3 pages", fc - fc0, 12);
        chk(fr_len[fc0+1] == 30 && fr_len[fc0+5] == 35 && fr_len[fc0+9] == 14, "R6", "page split lengths",
            fr_len[fc0+5], 35);
        chk(fr_op[fc0+4] == 8'h06 && fr_op[fc0+8] == 8'h06 && fr_wel[fc0+5] && fr_wel[fc0+9], "R5",
            "enable reissued", fr_op[fc0+4], 6);
        bad = 0;
        for (int i = 0; i < 70; i++) if (mem[16'h01C5 + i] != wbuf[i]) bad++;
        chk(bad == 0, "R6", "memory after split", bad, 0);
        do_cmd(3'd4, 16'h01C5, 70, 0);
        bad = 0;
        for (int i = 0; i < 70; i++) if (rbuf[i] != wbuf[i]) bad++;
        chk(fc - fc0 == 1 && fr_len[fc0] == 73, "R10", "one read frame", fr_len[fc0], 73);
        chk(r_n == 70 && bad == 0, "R10", "sequential data", bad, 0);
    endtask

    task automatic t_wrsr();
        m_busy_len = 2; wbuf[0] = 8'h8C;
        do_cmd(3'd3, 0, 0, 1);
        chk(fr_op[fc0+1] == 8'h01 && fr_len[fc0+1] == 2 && fr_op[fc0] == 8'h06, "R8", "status write frame",
            fr_op[fc0+1], 1);
        chk(fc - fc0 == 5, "R7", "status write polls", fc - fc0, 5);
        do_cmd(3'd2, 0, 0, 0);
        chk(rbuf[0] == 8'h8C, "R8", "status readback", rbuf[0], 8'h8C);
    endtask

    task automatic t_timeout();
        m_busy_len = 100000; wbuf[0] = 8'h11;
        do_cmd(3'd5, 16'd300, 1, 1);
        chk(err == 1, "R7", "err after timeout", err, 1);
        chk(fc - fc0 == 102, "R7", "poll limit frames", fc - fc0 - 2, 100);
        m_busy = 0; m_busy_len = 0;
        do_cmd(3'd2, 0, 0, 0);
        chk(err == 0, "R7", "err cleared by next command", err, 0);
    endtask

    task automatic t_len0();
        do_cmd(3'd4, 16'd155, 0, 0);
        chk(r_n == 1 && rbuf[0] == 8'hAA, "R10", "zero length read", r_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_latch();
        t_byte();
        t_pages();
        t_wrsr();
        t_timeout();
        t_len0();
        chk(v_mosi == 0, "R3", "data moved while clock high", v_mosi, 0);
        chk(v_half == 0, "R3", "clock high width", v_half, 0);
        chk(v_cs == 0, "R4", "select edge with clock high", v_cs, 0);
        chk(v_idle == 0, "R9", "data high while deselected", v_idle, 0);
        summary();
    end
endmodule